// File: doc/BRIEF.md
# Equal-Digit Parallel Carry Adder

This block adds two unsigned binary operands of a parameterised width and returns a sum one bit wider. It is purely combinational. No carry travels from one bit position to the next. Each carry is computed directly from the operand bits, so every output bit settles after a small, fixed number of logic levels. That number does not depend on the operand values.

The carry leaving any position is the value of the operand bits at the nearest position at or below it where the two operands hold the same value. When no such position exists, the carry is zero. In hardware, each carry is a wide OR. Each term of that OR is an "both ones" signal at some lower position, ANDed with the "either one" signals of every position between that one and the carry's own position. Each sum bit is then the exclusive OR of the operand bits at its position and the carry from the position below.

The block is meant to sit inside a larger datapath stage, between registers owned by the surrounding logic. It has no carry input. It handles neither signed operands nor subtraction.

Top module: `eqd_adder`

## Requirements
- R1: For every pair of operands, `sum_o` equals the arithmetic sum of `op_a` and `op_b`, taken as unsigned numbers on WIDTH+1 bits.
- R2: For every bit k, the carry out of k is determined by the nearest position j with j <= k where `op_a[j] == op_b[j]`. The carry is `op_a[j]` at that position, or 0 when no such position exists. This carry is observed as `sum_o[k+1] ^ op_a[k+1] ^ op_b[k+1]` for k < WIDTH-1, and as `sum_o[WIDTH]` for k = WIDTH-1.
- R3: `sum_o[0]` equals `op_a[0] ^ op_b[0]`.
- R4: When `op_a[WIDTH-1] == op_b[WIDTH-1]`, the top bit `sum_o[WIDTH]` equals `op_a[WIDTH-1]`.
- R5: All-zero operands give an all-zero sum. All-one operands give a sum whose top WIDTH bits are 1 and whose bit 0 is 0.
- R6: When the two operands differ in every position, the sum has bits WIDTH-1..0 all set and bit WIDTH clear.
- R7: The result depends only on the current operands. Applying the same pair of operands again gives the same sum, whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand, bit 0 least significant |
| op_b | input | WIDTH | Second unsigned operand, bit 0 least significant |
| sum_o | output | WIDTH+1 | Unsigned sum; bit WIDTH is the carry out of the top position |

## Verification
Every result of this block is due in the same clock cycle as the operands that produce it, because no register lies on any path from input to output. The bench drives new operands one time unit after a rising edge. It samples `sum_o` at the following falling edge, by which time the combinational network has settled. Each check therefore concerns only the operands of its own cycle. Repeating an earlier operand pair many cycles later shows that no state is carried from one cycle to the next.

// File: rtl/eqd_pkg.sv
package eqd_pkg;

  // Per-position signals derived from one bit of each operand.
  typedef struct packed {
    logic both;    // both operand bits are one
    logic either;  // at least one operand bit is one
    logic diff;    // operand bits differ
  } pos_sig_t;

  localparam int unsigned DEFAULT_WIDTH = 32;

endpackage

// File: rtl/eqd_pos_cells.sv
module eqd_pos_cells
  import eqd_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
  input  logic     [WIDTH-1:0] a_i,
  input  logic     [WIDTH-1:0] b_i,
  output pos_sig_t [WIDTH-1:0] sig_o
);

  // One level of logic per position: AND, OR and XOR side by side.
  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_pos
      assign sig_o[k].both   = a_i[k] & b_i[k];
      assign sig_o[k].either = a_i[k] | b_i[k];
      assign sig_o[k].diff   = a_i[k] ^ b_i[k];

      always_comb begin : chk_pos
        // a pair of bits is either equal (both set or none set) or differs
        assert_pos_class_R2: assert (sig_o[k].diff == (sig_o[k].either & ~sig_o[k].both));
      end
    end
  endgenerate

endmodule

// File: rtl/eqd_carry_net.sv
module eqd_carry_net #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] both_i,
  input  logic [WIDTH-1:0] either_i,
  output logic [WIDTH-1:0] carry_o
);

  // Carry n is a wide OR over start positions j <= n. Each term is
  // both[j] ANDed with either[] over positions j+1..n. The depth is one
  // AND level and one OR level above the position cells, for every n.
  generate
    for (genvar n = 0; n < WIDTH; n++) begin : g_col
      logic [n:0] term;

      for (genvar j = 0; j <= n; j++) begin : g_term
        if (j == n) begin : g_self
          assign term[j] = both_i[j];
        end else begin : g_span
          assign term[j] = both_i[j] & (&either_i[n:j+1]);
        end
      end

      assign carry_o[n] = |term;

      // Independent view of the same carry: walk down from n to the first
      // position where the operand bits agree and take its value.
      always_comb begin : chk_col
        logic hit;
        logic want;
        hit  = 1'b0;
        want = 1'b0;
        for (int k = n; k >= 0; k--) begin
          if (!hit && (both_i[k] | ~either_i[k])) begin
            hit  = 1'b1;
            want = both_i[k];
          end
        end
        assert_nearest_equal_R2: assert (carry_o[n] == want);
      end
    end
  endgenerate

endmodule

// File: rtl/eqd_sum_stage.sv
module eqd_sum_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH:0]   sum_o
);

  assign sum_o[0]     = diff_i[0];
  assign sum_o[WIDTH] = carry_i[WIDTH-1];

  generate
    for (genvar k = 1; k < WIDTH; k++) begin : g_bit
      // equivalence of equivalences, identical to a three-input XOR
      assign sum_o[k] = ~(~(diff_i[k] ^ carry_i[k-1]));
    end
  endgenerate

endmodule

// File: rtl/eqd_adder.sv
module eqd_adder
  import eqd_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH:0]   sum_o
);

  localparam int unsigned SUM_W = WIDTH + 1;

  pos_sig_t [WIDTH-1:0] sig;
  logic     [WIDTH-1:0] both_v;
  logic     [WIDTH-1:0] either_v;
  logic     [WIDTH-1:0] diff_v;
  logic     [WIDTH-1:0] carry_v;

  eqd_pos_cells #(.WIDTH(WIDTH)) u_cells (
    .a_i   (op_a),
    .b_i   (op_b),
    .sig_o (sig)
  );

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_split
      assign both_v[k]   = sig[k].both;
      assign either_v[k] = sig[k].either;
      assign diff_v[k]   = sig[k].diff;
    end
  endgenerate

  eqd_carry_net #(.WIDTH(WIDTH)) u_carry (
    .both_i   (both_v),
    .either_i (either_v),
    .carry_o  (carry_v)
  );

  eqd_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .diff_i  (diff_v),
    .carry_i (carry_v),
    .sum_o   (sum_o)
  );

  always_comb begin : chk_top
    assert_matches_add_R1: assert (sum_o == (SUM_W'(op_a) + SUM_W'(op_b)));
    assert_lsb_R3: assert (sum_o[0] == (op_a[0] ^ op_b[0]));
    if (op_a[WIDTH-1] == op_b[WIDTH-1]) begin
      assert_top_equal_R4: assert (sum_o[WIDTH] == op_a[WIDTH-1]);
    end
    if ((op_a ^ op_b) == {WIDTH{1'b1}}) begin
      assert_no_equal_pos_R6: assert (sum_o == {1'b0, {WIDTH{1'b1}}});
    end
  end

endmodule

// File: tb/test_eqd_adder.sv
module test_eqd_adder;

  localparam int unsigned WN = 6;
  localparam int unsigned WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [WN-1:0] na, nb;
  logic [WN:0]   ns;
  logic [WW-1:0] wa, wb;
  logic [WW:0]   ws;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned cycles = 0;
  bit          done   = 1'b0;

  eqd_adder #(.WIDTH(WN)) i_eqd_adder_narrow (.op_a(na), .op_b(nb), .sum_o(ns));
  eqd_adder #(.WIDTH(WW)) i_eqd_adder (.op_a(wa), .op_b(wb), .sum_o(ws));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Carries by the nearest-equal-position rule, computed without addition.
  function automatic logic [31:0] rule_carries(input logic [31:0] x, input logic [31:0] y,
                                               input int w);
    logic [31:0] c;
    c = '0;
    for (int k = 0; k < w; k++) begin
      logic hit;
      hit = 1'b0;
      for (int j = k; j >= 0; j--) begin
        if (!hit && x[j] == y[j]) begin
          hit  = 1'b1;
          c[k] = x[j];
        end
      end
    end
    return c;
  endfunction

  // Carries as seen at the sum output.
  function automatic logic [31:0] seen_carries(input logic [31:0] x, input logic [31:0] y,
                                               input logic [32:0] s, input int w);
    logic [31:0] c;
    c = '0;
    for (int k = 0; k < w; k++) begin
      if (k == w - 1) c[k] = s[w];
      else            c[k] = s[k+1] ^ x[k+1] ^ y[k+1];
    end
    return c;
  endfunction

  task automatic apply_wide(input logic [WW-1:0] x, input logic [WW-1:0] y);
    @(posedge clk);
    #1;
    wa = x;
    wb = y;
    @(negedge clk);
  endtask

  task automatic check_wide(input string tag);
    logic [WW:0] exp;
    exp = {1'b0, wa} + {1'b0, wb};
    check(ws == exp, {"R1 ", tag}, 64'(ws), 64'(exp));
    check(seen_carries(wa, wb, ws, WW) == rule_carries(wa, wb, WW), {"R2 ", tag},
          64'(seen_carries(wa, wb, ws, WW)), 64'(rule_carries(wa, wb, WW)));
  endtask

  initial begin
    logic [WW:0] first_sum;
    na = '0; nb = '0; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: zero operands give zero
    check(ws == '0, "R5 zero wide", 64'(ws), 64'd0);
    check(ns == '0, "R5 zero narrow", 64'(ns), 64'd0);

    // Exhaustive sweep of the narrow instance: R1, R2, R3, R4
    for (int a = 0; a < (1 << WN); a++) begin
      for (int b = 0; b < (1 << WN); b++) begin
        logic [WN:0] exp;
        @(posedge clk);
        #1;
        na = WN'(a);
        nb = WN'(b);
        @(negedge clk);
        exp = WN'(a) + WN'(b) + 7'd0;
        exp = (WN + 1)'(a) + (WN + 1)'(b);
        check(ns == exp, "R1 narrow sweep", 64'(ns), 64'(exp));
        check(seen_carries(32'(na), 32'(nb), 33'(ns), WN) == rule_carries(32'(na), 32'(nb), WN),
              "R2 narrow sweep", 64'(seen_carries(32'(na), 32'(nb), 33'(ns), WN)),
              64'(rule_carries(32'(na), 32'(nb), WN)));
        check(ns[0] == (na[0] ^ nb[0]), "R3 narrow lsb", 64'(ns[0]), 64'(na[0] ^ nb[0]));
        if (na[WN-1] == nb[WN-1])
          check(ns[WN] == na[WN-1], "R4 narrow top", 64'(ns[WN]), 64'(na[WN-1]));
      end
    end

    // R5: all ones
    apply_wide('1, '1);
    check(ws == {{WW{1'b1}}, 1'b0}, "R5 all ones", 64'(ws), 64'({{WW{1'b1}}, 1'b0}));
    // R6: complementary operands, no equal position
    apply_wide(32'hAAAA_AAAA, 32'h5555_5555);
    check(ws == {1'b0, {WW{1'b1}}}, "R6 alternating complement", 64'(ws), 64'({1'b0, {WW{1'b1}}}));
    apply_wide(32'h1234_5678, ~32'h1234_5678);
    check(ws == {1'b0, {WW{1'b1}}}, "R6 complement", 64'(ws), 64'({1'b0, {WW{1'b1}}}));
    // single equal position at bit 7, carry travels the whole width above
    apply_wide(32'hAAAA_AAAA, 32'h5555_55D5);
    check_wide("single equal position");
    apply_wide(32'hAAAA_AAAA, 32'hAAAA_AAAA);
    check_wide("alternating equal");
    // R4 wide: top bits both one, and both zero
    apply_wide(32'h8000_0001, 32'hFFFF_FFFF);
    check(ws[WW] == 1'b1, "R4 top both ones", 64'(ws[WW]), 64'd1);
    apply_wide(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check(ws[WW] == 1'b0, "R4 top both zero", 64'(ws[WW]), 64'd0);
    // long-chain vectors
    apply_wide(32'b10001101011010110010100000110100, 32'b11000010010111010101101110001011);
    check_wide("vector one");
    first_sum = ws;
    apply_wide(32'b10101101001101111001000001101001, 32'b11011000110010010110111110011100);
    check_wide("vector two");
    // random operands
    for (int r = 0; r < 2000; r++) begin
      apply_wide($urandom, $urandom);
      check_wide("random");
      check(ws[0] == (wa[0] ^ wb[0]), "R3 wide lsb", 64'(ws[0]), 64'(wa[0] ^ wb[0]));
    end
    // R7: repeat vector one after unrelated traffic
    apply_wide(32'b10001101011010110010100000110100, 32'b11000010010111010101101110001011);
    check(ws == first_sum, "R7 repeat gives same sum", 64'(ws), 64'(first_sum));

    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles >= 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule